// File: doc/BRIEF.md
# Split-Width Event Counter Unit

This block is a performance-monitoring counter unit. It holds four physical 32-bit counter registers. At runtime, software can split any one of them into two separate 16-bit counters, so the unit offers up to eight logical counters. Each logical counter picks one line of a 64-bit event bus. It can count the line's level, its rising edges or plain clock cycles. Counting happens only when the current privilege level passes a global filter.

Overflows are recorded as sticky status bits. The status bits are masked into a single interrupt line.

Software reaches every register through a single-cycle read/write port:
- Writes take effect at the next clock edge.
- Read data is combinational from the current register contents.
- Reading the status register returns its contents and clears it.

Register addresses (5-bit `addr_i`):

| Address | Register |
|---|---|
| 0 | global control |
| 1 | interrupt mask |
| 2 | status |
| 8+k | control word of logical counter k (k = 0..7) |
| 16+k | value of logical counter k (k = 0..7) |

Any other address reads as zero, and writes to it are ignored.

Top module: `evt_ctr_unit`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: Global control keeps only these bits and reads the rest as zero:
  - bit 31: enable
  - bit 30: stop-at-max
  - bits 24..21: split flags, bit (24-n) for physical counter n
  - bit 20: freeze
  - bits 19:18: privilege mode
  - The mask register keeps bits 7:0.
  - A logical control word keeps bits 31:22 and reads bits 21:0 as zero.
  - Writes to the status register have no effect.
- R3: With the split bit of physical counter n clear, logical counter n is one 32-bit counter. Logical counter n+4 reads zero, ignores writes, never counts and never flags overflow.
- R4: With the split bit of physical counter n set:
  - Logical counter n uses the low 16 bits and logical counter n+4 uses the high 16 bits.
  - Each half counts, wraps and overflows on its own.
  - Each half reads back zero-extended.
  - A write to one half loads `wdata_i[15:0]` into that half only.
- R5: A logical counter increments only when all of these hold: global enable (bit 31) set, freeze (bit 20) clear, and its own enable (bit 22) set.
- R6: The privilege mode field selects when counting is allowed:
  - mode 0: only when `priv_i`=0 (supervisor)
  - mode 1: only when `priv_i`=1 (hypervisor)
  - mode 2: only when `priv_i`=2 (user)
  - mode 3: always
- R7: Control word bits 31:26 select the event line.
  - Bit 24 inverts the selected line.
  - With bit 25 clear, the counter increments on every cycle the adjusted line is 1.
  - With bit 25 set, it increments only when the adjusted line is 1 and was 0 in the previous cycle. The previous value is taken as 0 after reset.
- R8: With control bit 23 set, a permitted counter increments on every clock, whatever its event line does.
- R9: When an increment hits a counter that is all ones, status bit (31-k) is set for logical counter k. With stop-at-max clear, the counter wraps to zero.
- R10: With stop-at-max set, the increment that hits all ones still sets the status bit, but the counter stays at all ones.
- R11: Status bits are sticky. A status read returns the current bits and clears them at the next edge. An overflow in that same cycle is still recorded.
- R12: `irq_o` is high exactly when some status bit k and mask bit k are both set.
- R13: A counter value write shows on the next cycle and overrides an increment of that counter in the same cycle. No overflow is recorded for that counter in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 64 | Event bus |
| priv_i | input | 2 | Current privilege level: 0 supervisor, 1 hypervisor, 2 user |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero when `rd_en_i` is low |
| irq_o | output | 1 | Interrupt request |

## Verification
The checker makes the following assumptions:
- A physical counter is frozen only when no value write reaches any counter in that cycle.
- Status bits change only through recorded overflows or a status read.
- `priv_i` carries one of the three defined levels.

The stimulus keeps within these assumptions by drawing `priv_i` from 0..2 only and by using only defined addresses. Random writes favour the global enable and seed counter values just below both the 16-bit and the 32-bit limits, so wrap, hold and split-half overflows happen often during cycle-count and event-driven runs.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int unsigned NUM_PHYS = 4;
  localparam int unsigned NUM_LOG  = 2 * NUM_PHYS;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned HALF_W   = DATA_W / 2;
  localparam int unsigned EVT_W    = 64;
  localparam int unsigned SEL_W    = $clog2(EVT_W);
  localparam int unsigned ADDR_W   = 5;

  localparam logic [1:0] REG_GLB  = 2'b00;
  localparam logic [1:0] REG_LCTL = 2'b01;
  localparam logic [1:0] REG_VAL  = 2'b10;
  localparam logic [2:0] IDX_GCTL = 3'd0;
  localparam logic [2:0] IDX_MASK = 3'd1;
  localparam logic [2:0] IDX_STAT = 3'd2;

  localparam int unsigned G_EN        = 31;
  localparam int unsigned G_STOP      = 30;
  localparam int unsigned G_SPLIT_TOP = 24;
  localparam int unsigned G_FRZ       = 20;
  localparam int unsigned G_MODE_LO   = 18;
  localparam int unsigned L_FIELD_LO  = 22;

  localparam logic [1:0] MODE_ALL = 2'd3;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             rise;
    logic             inv;
    logic             cyc;
    logic             en;
  } lctl_t;
endpackage

// File: rtl/evt_lane.sv
module evt_lane #(
  parameter int unsigned EVT_W = 64,
  parameter int unsigned SEL_W = $clog2(EVT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_W-1:0] evt_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             inv_i,
  input  logic             rise_i,
  input  logic             cyc_i,
  input  logic             gate_i,
  output logic             inc_o
);
  logic adj, prev_q;

  assign adj = evt_i[sel_i] ^ inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= adj;
  end

  assign inc_o = gate_i & (cyc_i | (rise_i ? (adj & ~prev_q) : adj));
endmodule

// File: rtl/evt_phys.sv
module evt_phys #(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned W      = 2 * HALF_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         split_i,
  input  logic         stop_i,
  input  logic         inc_lo_i,
  input  logic         inc_hi_i,
  input  logic         wr_lo_i,
  input  logic         wr_hi_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] val_o,
  output logic         ovf_lo_o,
  output logic         ovf_hi_o
);
  localparam logic [W-1:0]      ONE_W = W'(1);
  localparam logic [HALF_W-1:0] ONE_H = HALF_W'(1);

  logic [W-1:0] val_q, val_d;

  always_comb begin
    val_d    = val_q;
    ovf_lo_o = 1'b0;
    ovf_hi_o = 1'b0;
    if (!split_i) begin
      if (wr_lo_i) val_d = wdata_i;
      else if (inc_lo_i) begin
        if (&val_q) begin
          ovf_lo_o = 1'b1;
          if (!stop_i) val_d = '0;
        end else val_d = val_q + ONE_W;
      end
    end else begin
      if (wr_lo_i) val_d[HALF_W-1:0] = wdata_i[HALF_W-1:0];
      else if (inc_lo_i) begin
        if (&val_q[HALF_W-1:0]) begin
          ovf_lo_o = 1'b1;
          if (!stop_i) val_d[HALF_W-1:0] = '0;
        end else val_d[HALF_W-1:0] = val_q[HALF_W-1:0] + ONE_H;
      end
      if (wr_hi_i) val_d[W-1:HALF_W] = wdata_i[HALF_W-1:0];
      else if (inc_hi_i) begin
        if (&val_q[W-1:HALF_W]) begin
          ovf_hi_o = 1'b1;
          if (!stop_i) val_d[W-1:HALF_W] = '0;
        end else val_d[W-1:HALF_W] = val_q[W-1:HALF_W] + ONE_H;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else         val_q <= val_d;
  end

  assign val_o = val_q;
endmodule

// File: rtl/evt_ctr_unit.sv
module evt_ctr_unit
  import evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic [1:0]        priv_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned PIW = $clog2(NUM_PHYS);
  localparam int unsigned LIW = $clog2(NUM_LOG);

  logic                             en_q, stop_q, frz_q;
  logic [1:0]                       mode_q;
  logic [NUM_PHYS-1:0]              split_q;
  logic [NUM_LOG-1:0]               mask_q, stat_q, ovf, inc;
  lctl_t                            lctl_q [NUM_LOG];
  logic [NUM_PHYS-1:0][DATA_W-1:0]  phys_val;

  logic [1:0]     region;
  logic [LIW-1:0] idx;
  logic           wr_g, wr_m, wr_l, wr_v, rd_stat, run, priv_ok;

  assign region  = addr_i[ADDR_W-1:ADDR_W-2];
  assign idx     = addr_i[LIW-1:0];
  assign wr_g    = wr_en_i && region == REG_GLB && idx == IDX_GCTL;
  assign wr_m    = wr_en_i && region == REG_GLB && idx == IDX_MASK;
  assign wr_l    = wr_en_i && region == REG_LCTL;
  assign wr_v    = wr_en_i && region == REG_VAL;
  assign rd_stat = rd_en_i && region == REG_GLB && idx == IDX_STAT;
  assign run     = en_q & ~frz_q;
  assign priv_ok = (mode_q == MODE_ALL) || (priv_i == mode_q);

  for (genvar k = 0; k < NUM_LOG; k++) begin : g_lane
    evt_lane #(.EVT_W(EVT_W), .SEL_W(SEL_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt_i),
      .sel_i  (lctl_q[k].sel),
      .inv_i  (lctl_q[k].inv),
      .rise_i (lctl_q[k].rise),
      .cyc_i  (lctl_q[k].cyc),
      .gate_i (run & priv_ok & lctl_q[k].en),
      .inc_o  (inc[k])
    );
  end

  for (genvar n = 0; n < NUM_PHYS; n++) begin : g_phys
    evt_phys #(.HALF_W(HALF_W)) u_phys (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .split_i  (split_q[n]),
      .stop_i   (stop_q),
      .inc_lo_i (inc[n]),
      .inc_hi_i (inc[n+NUM_PHYS]),
      .wr_lo_i  (wr_v && idx == LIW'(n)),
      .wr_hi_i  (wr_v && idx == LIW'(n + NUM_PHYS)),
      .wdata_i  (wdata_i),
      .val_o    (phys_val[n]),
      .ovf_lo_o (ovf[n]),
      .ovf_hi_o (ovf[n+NUM_PHYS])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      stop_q  <= 1'b0;
      frz_q   <= 1'b0;
      mode_q  <= '0;
      split_q <= '0;
      mask_q  <= '0;
      stat_q  <= '0;
      for (int k = 0; k < NUM_LOG; k++) lctl_q[k] <= '0;
    end else begin
      if (wr_g) begin
        en_q   <= wdata_i[G_EN];
        stop_q <= wdata_i[G_STOP];
        frz_q  <= wdata_i[G_FRZ];
        mode_q <= wdata_i[G_MODE_LO+1:G_MODE_LO];
        for (int n = 0; n < NUM_PHYS; n++) split_q[n] <= wdata_i[G_SPLIT_TOP-n];
      end
      if (wr_m) mask_q <= wdata_i[NUM_LOG-1:0];
      if (wr_l) lctl_q[idx] <= wdata_i[DATA_W-1:L_FIELD_LO];
      // set wins over read-clear
      stat_q <= (rd_stat ? '0 : stat_q) | ovf;
    end
  end

  assign irq_o = |(stat_q & mask_q);

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (region)
        REG_GLB: begin
          case (idx)
            IDX_GCTL: begin
              rdata_o[G_EN]                  = en_q;
              rdata_o[G_STOP]                = stop_q;
              rdata_o[G_FRZ]                 = frz_q;
              rdata_o[G_MODE_LO+1:G_MODE_LO] = mode_q;
              for (int n = 0; n < NUM_PHYS; n++) rdata_o[G_SPLIT_TOP-n] = split_q[n];
            end
            IDX_MASK: rdata_o[NUM_LOG-1:0] = mask_q;
            IDX_STAT: for (int k = 0; k < NUM_LOG; k++) rdata_o[DATA_W-1-k] = stat_q[k];
            default: ;
          endcase
        end
        REG_LCTL: rdata_o[DATA_W-1:L_FIELD_LO] = lctl_q[idx];
        REG_VAL: begin
          if (!idx[PIW]) begin
            if (split_q[idx[PIW-1:0]]) rdata_o[HALF_W-1:0] = phys_val[idx[PIW-1:0]][HALF_W-1:0];
            else                       rdata_o = phys_val[idx[PIW-1:0]];
          end else if (split_q[idx[PIW-1:0]]) begin
            rdata_o[HALF_W-1:0] = phys_val[idx[PIW-1:0]][DATA_W-1:HALF_W];
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/evt_ctr_unit_chk.sv
module evt_ctr_unit_chk
  import evt_pkg::*;
(
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            wr_en_i,
  input logic                            rd_en_i,
  input logic [ADDR_W-1:0]               addr_i,
  input logic                            run_i,
  input logic                            stop_i,
  input logic [NUM_PHYS-1:0]             split_i,
  input logic [NUM_LOG-1:0]              stat_i,
  input logic [NUM_LOG-1:0]              ovf_i,
  input logic [NUM_PHYS-1:0][DATA_W-1:0] phys_val_i
);
  logic val_wr, stat_rd;
  assign val_wr  = wr_en_i && addr_i[ADDR_W-1:ADDR_W-2] == REG_VAL;
  assign stat_rd = rd_en_i && addr_i == ADDR_W'(IDX_STAT);

  a_r5_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !val_wr) |=> $stable(phys_val_i));

  a_r11_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd |=> ((stat_i & ~$past(ovf_i)) == '0));

  a_r11_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_rd |=> ((stat_i & $past(stat_i)) == $past(stat_i)));

  for (genvar n = 0; n < NUM_PHYS; n++) begin : g_chk
    a_r3_no_upper_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_i[n+NUM_PHYS] |-> split_i[n]);

    a_r10_hold_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stop_i && !split_i[n] && (&phys_val_i[n]) && !val_wr) |=> (&phys_val_i[n]));
  end
endmodule

bind evt_ctr_unit evt_ctr_unit_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .run_i      (run),
  .stop_i     (stop_q),
  .split_i    (split_q),
  .stat_i     (stat_q),
  .ovf_i      (ovf),
  .phys_val_i (phys_val)
);

// File: tb/evt_ctr_unit_tb_top.sv
`timescale 1ns/1ps
module evt_ctr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] evt;
  logic [1:0]  priv;
  logic        wr_en, rd_en;
  logic [4:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq;

  always #4 clk = ~clk;

  evt_ctr_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .priv_i(priv),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  logic [31:0] m_gctl, m_val[4], m_lctl[8];
  logic [7:0]  m_mask, m_stat, m_prev;
  logic [63:0] cur_ev;
  logic [1:0]  cur_pv;

  function automatic logic [31:0] mread(logic [4:0] a);
    logic [31:0] r;
    int k;
    r = '0;
    if (a == 0) r = m_gctl & 32'hC1FC_0000;
    else if (a == 1) r = {24'h0, m_mask};
    else if (a == 2) for (int i = 0; i < 8; i++) r[31-i] = m_stat[i];
    else if (a >= 8 && a < 16) r = m_lctl[a-8];
    else if (a >= 16 && a < 24) begin
      k = int'(a) - 16;
      if (m_gctl[24-(k%4)]) r = (k < 4) ? {16'h0, m_val[k%4][15:0]} : {16'h0, m_val[k%4][31:16]};
      else if (k < 4) r = m_val[k];
    end
    return r;
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(bit w, bit r, logic [4:0] a, logic [31:0] wd);
    logic [7:0]  inc, nprev, ovf;
    logic [31:0] nval[4];
    logic        runm, pok, adj, sp;
    logic [31:0] c;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = wd; evt = cur_ev; priv = cur_pv;
    #1;
    if (r) check(rdata, mread(a), cur_req);
    else check(rdata, 32'h0, "R2");
    check({31'h0, irq}, {31'h0, |(m_stat & m_mask)}, "R12");
    runm = m_gctl[31] & ~m_gctl[20];
    pok  = (m_gctl[19:18] == 2'd3) || (cur_pv == m_gctl[19:18]);
    for (int k = 0; k < 8; k++) begin
      c = m_lctl[k];
      adj = cur_ev[c[31:26]] ^ c[24];
      inc[k] = runm && pok && c[22] && (c[23] || (c[25] ? (adj && !m_prev[k]) : adj));
      nprev[k] = adj;
    end
    ovf = '0;
    for (int n = 0; n < 4; n++) begin
      nval[n] = m_val[n];
      sp = m_gctl[24-n];
      if (!sp) begin
        if (w && a == 5'(16+n)) nval[n] = wd;
        else if (inc[n]) begin
          if (m_val[n] == 32'hFFFF_FFFF) begin ovf[n] = 1'b1; if (!m_gctl[30]) nval[n] = 0; end
          else nval[n] = m_val[n] + 1;
        end
      end else begin
        if (w && a == 5'(16+n)) nval[n][15:0] = wd[15:0];
        else if (inc[n]) begin
          if (m_val[n][15:0] == 16'hFFFF) begin ovf[n] = 1'b1; if (!m_gctl[30]) nval[n][15:0] = 0; end
          else nval[n][15:0] = m_val[n][15:0] + 16'd1;
        end
        if (w && a == 5'(20+n)) nval[n][31:16] = wd[15:0];
        else if (inc[n+4]) begin
          if (m_val[n][31:16] == 16'hFFFF) begin ovf[n+4] = 1'b1; if (!m_gctl[30]) nval[n][31:16] = 0; end
          else nval[n][31:16] = m_val[n][31:16] + 16'd1;
        end
      end
    end
    @(posedge clk);
    m_stat = ((r && a == 5'd2) ? 8'h0 : m_stat) | ovf;
    m_prev = nprev;
    for (int n = 0; n < 4; n++) m_val[n] = nval[n];
    if (w) begin
      if (a == 0) m_gctl = wd;
      else if (a == 1) m_mask = wd[7:0];
      else if (a >= 8 && a < 16) m_lctl[a-8] = wd & 32'hFFC0_0000;
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d); step(1'b1, 1'b0, a, d); endtask
  task automatic rd(logic [4:0] a); step(1'b0, 1'b1, a, 32'h0); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) step(1'b0, 1'b0, 5'd0, 32'h0); endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [4:0]  a;
    logic [31:0] d;
    int          p;
    void'($urandom(32'd20240611));
    m_gctl = 0; m_mask = 0; m_stat = 0; m_prev = 0;
    for (int i = 0; i < 4; i++) m_val[i] = 0;
    for (int i = 0; i < 8; i++) m_lctl[i] = 0;
    cur_ev = 0; cur_pv = 0;
    rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; evt = 0; priv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1";
    for (int i = 0; i < 24; i++) rd(5'(i));

    cur_req = "R2";
    wr(0, 32'hFFFF_FFFF); rd(0);
    wr(0, 32'h0); wr(1, 32'hFFFF_FFA5); rd(1);
    wr(8, 32'hFFFF_FFFF); rd(8); wr(8, 0);
    wr(2, 32'hFFFF_FFFF); rd(2);
    wr(1, 32'h0);

    cur_req = "R8";
    wr(0, 32'h800C_0000);
    wr(8, 32'h00C0_0000);
    wr(16, 32'd5); idle(3); rd(16);
    cur_req = "R13";
    wr(16, 32'd100); rd(16); rd(16);

    cur_req = "R3";
    wr(20, 32'h1234_5678); rd(20); wr(12, 32'h00C0_0000); idle(2); rd(20); rd(2);

    cur_req = "R9";
    wr(1, 32'hFF); wr(16, 32'hFFFF_FFFE); idle(1); rd(16); idle(1); rd(16);
    cur_req = "R11";
    rd(2); rd(2);

    cur_req = "R10";
    wr(0, 32'hC00C_0000); wr(16, 32'hFFFF_FFFE); idle(3); rd(16); rd(2);

    cur_req = "R4";
    wr(0, 32'h808C_0000);
    wr(9, 32'h00C0_0000); wr(13, 32'h00C0_0000);
    wr(17, 32'h0000_FFFE); wr(21, 32'hABCD_0010);
    idle(2); rd(17); rd(21); rd(2); rd(17); rd(21);

    cur_req = "R7";
    wr(0, 32'h800C_0000); wr(9, 0); wr(13, 0); wr(12, 0);
    wr(10, 32'h1440_0000); wr(18, 0);
    cur_ev = 64'h20; idle(3); rd(18);
    wr(10, 32'h1640_0000); wr(18, 0);
    cur_ev = 0; idle(1); cur_ev = 64'h20; idle(2); cur_ev = 0; idle(1); cur_ev = 64'h20; idle(1); rd(18);
    wr(10, 32'h1540_0000); wr(18, 0); cur_ev = 64'h20; idle(2); cur_ev = 0; idle(3); rd(18);

    cur_req = "R6";
    wr(10, 32'h00C0_0000); wr(18, 0);
    wr(0, 32'h8004_0000);
    cur_pv = 0; idle(3); rd(18); cur_pv = 1; idle(3); rd(18); cur_pv = 2; idle(2); rd(18);
    wr(0, 32'h8000_0000); cur_pv = 0; idle(2); rd(18);

    cur_req = "R5";
    wr(0, 32'h801C_0000); idle(3); rd(18);
    wr(0, 32'h000C_0000); idle(3); rd(18);
    wr(0, 32'h800C_0000); wr(10, 32'h0080_0000); idle(3); rd(18);

    cur_req = "R12";
    wr(1, 32'h0); wr(0, 32'h800C_0000); wr(8, 32'h00C0_0000); wr(16, 32'hFFFF_FFFF);
    idle(2); rd(2); wr(1, 32'h01); idle(1); wr(16, 32'hFFFF_FFFF); idle(2); rd(2); idle(1);

    cur_req = "R4";
    for (int i = 0; i < 3000; i++) begin
      cur_ev = {$urandom, $urandom};
      cur_pv = 2'($urandom % 3);
      p = int'($urandom % 19);
      a = (p < 3) ? 5'(p) : 5'(p + 5);
      if ($urandom % 6 == 0) begin
        d = $urandom;
        if (a == 0) begin
          d[31] = ($urandom % 4) != 0;
          d[20] = ($urandom % 6) == 0;
        end else if (a >= 16) begin
          case ($urandom % 3)
            0: d = 32'hFFFF_FFF0 | ($urandom % 16);
            1: d = 32'h0000_FFF0 | ($urandom % 16);
            default: ;
          endcase
        end
        wr(a, d);
      end else begin
        rd(a);
      end
    end

    summary();
    $finish;
  end
endmodule